// File: doc/BRIEF.md
# Differential Spread-Spectrum Baseband Modulator

This block turns a stream of information bits into the transmit baseband sample stream of a direct-sequence spread-spectrum link that a noncoherent receiver can decode. Each accepted bit first passes through a differential encoder. The encoder keeps a running coded symbol and multiplies it by the new bit's antipodal value, so the information sits in the product of two consecutive coded symbols. The receiver then needs no carrier phase tracking.

The coded symbol is multiplied by a pseudo-noise chip pattern of `CHIPS_PER_BIT` chips (default 25). Each chip is held for `SAMPLES_PER_CHIP` output samples (default 16), which gives 400 samples per bit. Samples leave the block as signed values of fixed magnitude, one per strobe. A clock-enable divider sets the strobe rate at `STROBE_DIV` system clocks per sample. For a 4 kHz sample rate, `STROBE_DIV` is set to the system clock frequency divided by 4000.

Bits enter through a valid/ready handshake, and the block applies back-pressure for the whole length of a bit. `bit_ready` falls once a bit is taken and returns only in the cycle that carries that bit's final sample. The output has no back-pressure: samples are produced at the strobe rate, and the consumer must take each one.

Top module: `dsss_diff_mod`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, the outputs are `bit_ready`=1, `smp_stb`=0 and `smp_data`=0, and the encoder's reference symbol is +1. A bit 1 sent first after reset therefore codes to +1.
- R2: A bit is taken at a rising clock edge where `bit_valid` and `bit_ready` are both high. `bit_ready` is low from the next cycle on. It rises again only in the cycle that presents that bit's final `smp_stb`. If `bit_valid` is held high, the next bit is taken at the edge that follows.
- R3: An information bit maps 0 to -1 and 1 to +1. The coded symbol is d(n) = a(n)·d(n-1), where a(n) is the mapped input bit.
- R4: Every accepted bit produces exactly `CHIPS_PER_BIT`*`SAMPLES_PER_CHIP` strobes (400 by default).
- R5: The chip generator is a 5-bit shift register loaded with 5'b00001 at every bit acceptance. The chip value is its bit 4 (1 maps to +1, 0 maps to -1). After every `SAMPLES_PER_CHIP` samples it shifts left, and the new bit 0 is bit 4 XOR bit 2. Each sample is +`AMPLITUDE` when the coded symbol and the chip have the same sign, and -`AMPLITUDE` otherwise.
- R6: Within a bit, consecutive strobes are exactly `STROBE_DIV` clock cycles apart.
- R7: No strobe occurs while no bit is in progress, and `smp_data` is 0 in every cycle where `smp_stb` is low.
- R8: `bit_valid` and `bit_data` have no effect while `bit_ready` is low. The samples of the bit in progress stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Information bit offered |
| bit_data | input | 1 | Information bit value |
| bit_ready | output | 1 | Block can take a bit |
| smp_stb | output | 1 | One-cycle sample strobe |
| smp_data | output | SMP_W | Signed output sample, zero between strobes |

## Verification
The stimulus is a fixed run of information bits. It contains repeats and alternations of both values, so each coded symbol tells a correct differential product apart from a plain copy of the input bit or an inverted reference. Every one of the 400 samples in each bit is compared with a chip model built from the stated register rule. This catches chip order, chip length and shift timing errors. Further directed runs cover four cases: valid held high across back-to-back bits, toggling inputs during a bit, an idle stretch, and a reset in the middle of a bit. The reset run restores the +1 reference and is chosen so that a lost reset gives the opposite coded symbol.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  // Antipodal symbol held as one bit: 1 stands for +1, 0 stands for -1
  typedef enum logic {
    SYM_NEG = 1'b0,
    SYM_POS = 1'b1
  } sym_t;

  // Product of two antipodal symbols in the one-bit encoding
  function automatic sym_t sym_mul(input sym_t a, input sym_t b);
    return sym_t'(a ~^ b);
  endfunction
endpackage

// File: rtl/dsss_strobe_div.sv
module dsss_strobe_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/dsss_pn_lfsr.sv
module dsss_pn_lfsr #(
  parameter int           W    = 5,
  parameter logic [W-1:0] TAPS = 5'b10100,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic chip
);
  logic [W-1:0] state;
  logic         fb;

  assign fb   = ^(state & TAPS);
  assign chip = state[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (load) state <= SEED;
    else if (step) state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/dsss_diff_enc.sv
module dsss_diff_enc
  import dsss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic info_bit,
  output sym_t sym
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sym <= SYM_POS;
    else if (load) sym <= sym_mul(sym_t'(info_bit), sym);
  end
endmodule

// File: rtl/dsss_seq_ctrl.sv
module dsss_seq_ctrl #(
  parameter int CPB = 25,
  parameter int SPC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic tick,
  output logic busy,
  output logic emit,
  output logic chip_adv
);
  localparam int SW = (SPC > 1) ? $clog2(SPC) : 1;
  localparam int CW = (CPB > 1) ? $clog2(CPB) : 1;

  logic [SW-1:0] s_idx;
  logic [CW-1:0] c_idx;
  logic          end_chip;
  logic          end_bit;

  assign emit     = busy && tick;
  assign end_chip = emit && (s_idx == SW'(SPC - 1));
  assign end_bit  = end_chip && (c_idx == CW'(CPB - 1));
  assign chip_adv = end_chip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      s_idx <= '0;
      c_idx <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      s_idx <= '0;
      c_idx <= '0;
    end else if (emit) begin
      s_idx <= end_chip ? '0 : s_idx + SW'(1);
      if (end_bit) begin
        busy  <= 1'b0;
        c_idx <= '0;
      end else if (end_chip) begin
        c_idx <= c_idx + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dsss_diff_mod.sv
module dsss_diff_mod
  import dsss_pkg::*;
#(
  parameter int CHIPS_PER_BIT    = 25,
  parameter int SAMPLES_PER_CHIP = 16,
  parameter int STROBE_DIV       = 4,
  parameter int SMP_W            = 8,
  parameter int AMPLITUDE        = 64,
  parameter int PN_W             = 5,
  parameter logic [PN_W-1:0] PN_TAPS = 5'b10100,
  parameter logic [PN_W-1:0] PN_SEED = 5'b00001
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_valid,
  input  logic                    bit_data,
  output logic                    bit_ready,
  output logic                    smp_stb,
  output logic signed [SMP_W-1:0] smp_data
);
  localparam logic signed [SMP_W-1:0] POS_AMP = SMP_W'(AMPLITUDE);
  localparam logic signed [SMP_W-1:0] NEG_AMP = -POS_AMP;

  logic tick, busy, emit, chip_adv, accept, chip;
  sym_t coded_sym;

  assign bit_ready = !busy;
  assign accept    = bit_valid && bit_ready;

  dsss_strobe_div #(.DIV(STROBE_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  dsss_seq_ctrl #(.CPB(CHIPS_PER_BIT), .SPC(SAMPLES_PER_CHIP)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .tick(tick),
    .busy(busy), .emit(emit), .chip_adv(chip_adv)
  );

  dsss_diff_enc u_enc (
    .clk(clk), .rst_n(rst_n), .load(accept), .info_bit(bit_data),
    .sym(coded_sym)
  );

  dsss_pn_lfsr #(.W(PN_W), .TAPS(PN_TAPS), .SEED(PN_SEED)) u_pn (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(chip_adv),
    .chip(chip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_stb  <= 1'b0;
      smp_data <= '0;
    end else if (emit) begin
      smp_stb  <= 1'b1;
      smp_data <= (sym_mul(coded_sym, sym_t'(chip)) == SYM_POS) ? POS_AMP : NEG_AMP;
    end else begin
      smp_stb  <= 1'b0;
      smp_data <= '0;
    end
  end
endmodule

// File: rtl/dsss_diff_mod_chk.sv
module dsss_diff_mod_chk #(
  parameter int TOTAL = 400,
  parameter int AMP   = 64,
  parameter int SMP_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bit_valid,
  input logic                    bit_ready,
  input logic                    smp_stb,
  input logic signed [SMP_W-1:0] smp_data,
  input logic                    coded_sym
);
  logic [15:0] stb_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       stb_cnt <= '0;
    else if (bit_valid && bit_ready)  stb_cnt <= '0;
    else if (smp_stb)                 stb_cnt <= stb_cnt + 16'd1;
  end

  assert_take_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready) |=> !bit_ready);

  assert_ready_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_ready) |-> (smp_stb && stb_cnt == 16'(TOTAL - 1)));

  assert_no_excess_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (stb_cnt < 16'(TOTAL)));

  assert_sample_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (smp_data == SMP_W'(AMP) || smp_data == -SMP_W'(AMP)));

  assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |-> (smp_data == '0));

  assert_sym_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ready |=> $stable(coded_sym));
endmodule

bind dsss_diff_mod dsss_diff_mod_chk #(
  .TOTAL(CHIPS_PER_BIT * SAMPLES_PER_CHIP),
  .AMP(AMPLITUDE),
  .SMP_W(SMP_W)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .bit_valid(bit_valid),
  .bit_ready(bit_ready),
  .smp_stb(smp_stb),
  .smp_data(smp_data),
  .coded_sym(coded_sym)
);

// File: tb/dsss_diff_mod_tb_top.sv
module dsss_diff_mod_tb_top;
  localparam int CPB   = 25;
  localparam int SPC   = 16;
  localparam int DIV   = 4;
  localparam int SMP_W = 8;
  localparam int AMP   = 64;
  localparam int TOTAL = CPB * SPC;
  localparam int NVEC  = 8;
  // {information bit, expected coded symbol (1 = +1)}
  localparam logic [1:0] VEC [NVEC] = '{2'b11, 2'b00, 2'b01, 2'b11,
                                        2'b00, 2'b10, 2'b10, 2'b01};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready, smp_stb;
  logic signed [SMP_W-1:0] smp_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dsss_diff_mod dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .smp_stb(smp_stb), .smp_data(smp_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Expected sample k of a bit with coded symbol d (model of R3/R5)
  function automatic int exp_sample(input bit d, input int k);
    logic [4:0] st = 5'b00001;
    for (int c = 0; c < k / SPC; c++) st = {st[3:0], st[4] ^ st[2]};
    return (d == st[4]) ? AMP : -AMP;
  endfunction

  task automatic send(input bit b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_data  = b;
  endtask

  // Observe one bit from the cycle after its acceptance until ready returns
  task automatic collect(input bit d, input bit hold, input bit noisy,
                         input string tag);
    int n = 0, cyc = 0, last = -1, gap_bad = 0, bad = 0;
    int bad_act = 0, bad_exp = 0, e;
    bit done = 0, end_stb = 0;
    while (!done && cyc < TOTAL * DIV + 4 * DIV + 10) begin
      @(negedge clk);
      cyc++;
      if (noisy) begin
        bit_valid = (n < 200);
        bit_data  = ~bit_data;
      end else if (!hold) begin
        bit_valid = 1'b0;
      end
      if (smp_stb) begin
        e = exp_sample(d, n);
        if (int'(smp_data) != e) begin
          if (bad == 0) begin bad_act = int'(smp_data); bad_exp = e; end
          bad++;
        end
        if (last >= 0 && cyc - last != DIV) gap_bad++;
        last = cyc;
        n++;
      end
      if (bit_ready) begin
        done = 1;
        end_stb = smp_stb;
      end
    end
    check(bad == 0, "R3 R5", {tag, " sample values"}, bad_act, bad_exp);
    check(n == TOTAL, "R4", {tag, " strobe count"}, n, TOTAL);
    check(gap_bad == 0, "R6", {tag, " strobe spacing errors"}, gap_bad, 0);
    check(end_stb == 1'b1, "R2", {tag, " ready returns with last strobe"}, end_stb, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int idle_stb, idle_dat;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(bit_ready == 1'b1, "R1", "ready in reset", bit_ready, 1);
    check(smp_stb == 1'b0, "R1", "stb in reset", smp_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp_data == 0, "R1", "data after reset", int'(smp_data), 0);

    // Table of bits and expected coded symbols
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][1]);
      collect(VEC[i][0], 1'b0, 1'b0, $sformatf("vec%0d", i));
    end

    // R2: valid held high, two zero bits back to back (reference is +1)
    send(1'b0);
    collect(1'b0, 1'b1, 1'b0, "held first");
    collect(1'b1, 1'b0, 1'b0, "held second");

    // R8: inputs toggle while a bit is in progress
    send(1'b1);
    collect(1'b1, 1'b0, 1'b1, "R8 noisy");

    // R7: idle stretch
    idle_stb = 0; idle_dat = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (smp_stb) idle_stb++;
      if (smp_data != 0) idle_dat++;
    end
    check(idle_stb == 0, "R7", "idle strobes", idle_stb, 0);
    check(idle_dat == 0, "R7", "idle nonzero data", idle_dat, 0);

    // R1: reset mid-bit restores +1 reference (without it bit 1 would code to -1)
    send(1'b0);
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(bit_ready == 1'b1, "R1", "ready after mid-bit reset", bit_ready, 1);
    check(smp_stb == 1'b0, "R1", "stb after mid-bit reset", smp_stb, 0);
    rst_n = 1'b1;
    send(1'b1);
    collect(1'b1, 1'b0, 1'b0, "R1 after reset");

    summary();
    $finish;
  end
endmodule